// File: doc/BRIEF.md
# Handshaked SPI Master

This block is an SPI master that gates every frame with three sideband lines alongside chip select, serial clock and the two data lines. The master drives one of them, a request line. The slave drives the other two: a ready line and an acknowledge line. To write a frame, the master raises the request and holds chip select and the clock idle until the slave reports ready. It then shifts one full-duplex frame in SPI mode 0. Last, it waits a bounded number of cycles for the slave to acknowledge that the frame was buffered.

The slave can also start a transfer. When the ready line rises while the master is idle and has no request of its own, the master clocks in one frame from the slave. During that frame it holds the outgoing data line low. It then presents the received word with a one-cycle valid strobe.

Ready and acknowledge come from another clock domain, so each passes through a two-flop synchronizer. After every frame the master waits until both lines are low again before it takes a new request. This keeps a slow slave from having one stale level counted as a new event.

Top module: `hs_spi_master`

## Requirements
- R1: While reset is low and on the first cycle after it, `spi_cs_n` is 1, `spi_sclk` is 0, and `hs_ind`, `busy`, `done`, `ack_err` and `rd_valid` are all 0.
- R2: A `start` pulse in idle raises `hs_ind` on the next clock edge and sets `busy`. While `hs_rdy` stays low, `spi_cs_n` stays 1 and `spi_sclk` stays 0, however long the wait.
- R3: After `hs_rdy` rises, `spi_cs_n` goes to 0 on the third rising clock edge. On that same edge `hs_ind` returns to 0.
- R4: A frame is FRAME_W bits in mode 0, most significant bit first. `spi_sclk` idles low, has period CLK_DIV clocks, and gives exactly FRAME_W rising edges. `spi_cs_n` stays low for FRAME_W*CLK_DIV clocks. `spi_mosi` changes only on a falling `spi_sclk` edge. `spi_miso` is sampled on each rising edge, and the word received appears on `rd_data` when `spi_cs_n` returns high.
- R5: After a write frame, a rising `hs_ack` produces a one-cycle `done` pulse on the third clock edge after the change.
- R6: If no acknowledge edge arrives within ACK_TO clocks after `spi_cs_n` returns high from a write frame, `ack_err` pulses for one cycle exactly ACK_TO clocks after that point, and `done` does not pulse.
- R7: A rise of `hs_rdy` while the master is idle with no request starts a read frame. In a read frame `hs_ind` stays 0, `spi_mosi` is held at 0, and `rd_valid` pulses for one cycle on the edge where `spi_cs_n` returns high, with `rd_data` holding the word. Write frames never pulse `rd_valid`.
- R8: After any frame, `busy` stays 1 and a `start` pulse is ignored (no `hs_ind`) until both synchronized `hs_rdy` and `hs_ack` are low. A `hs_rdy` still high at that time does not start a read.
- R9: A `start` pulse while `busy` is 1 has no effect: no request is raised after the current frame completes.
- R10: At most one of `done`, `ack_err` and `rd_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to write `tx_data` |
| tx_data | input | FRAME_W | Word to send, captured with `start` |
| busy | output | 1 | High whenever the master is not idle |
| done | output | 1 | One-cycle pulse: write frame acknowledged |
| ack_err | output | 1 | One-cycle pulse: acknowledge timeout |
| rd_valid | output | 1 | One-cycle pulse: slave-initiated frame received |
| rd_data | output | FRAME_W | Word received in the last frame |
| hs_ind | output | 1 | Request to the slave to prepare for a write |
| hs_rdy | input | 1 | Slave ready, asynchronous |
| hs_ack | input | 1 | Slave acknowledge, asynchronous |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The bench sweeps write and read frames across a range of 8-bit words, including all-zeros and all-ones. A misordered or off-by-one shift engine would show up as a swapped or truncated word at either end. It measures the cycle latency from ready to chip select, from acknowledge to `done`, and to the timeout strobe, so a missing or extra synchronizer stage or an off-by-one timer fails on an exact count. It holds ready and acknowledge high after a frame and issues `start` during that time and during a frame. A design that skipped the settle rule would start a phantom read or a stray request there.

// File: rtl/hs_spi_master.sv
module hs_spi_master #(
  parameter int FRAME_W = 32,
  parameter int CLK_DIV = 4,
  parameter int ACK_TO  = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               busy,
  output logic               done,
  output logic               ack_err,
  output logic               rd_valid,
  output logic [FRAME_W-1:0] rd_data,
  output logic               hs_ind,
  input  logic               hs_rdy,
  input  logic               hs_ack,
  output logic               spi_cs_n,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int TW   = $clog2(ACK_TO + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_XFER, S_ACKW, S_SETL} st_t;
  st_t state;

  logic [1:0] rdy_sync, ack_sync;
  logic       rdy_d, ack_d;
  logic [FRAME_W-1:0] tx_sr, rx_sr;
  logic [DW-1:0] div;
  logic [BW-1:0] bitc;
  logic [TW-1:0] tmr;
  logic          is_rd;

  wire rdy_s    = rdy_sync[1];
  wire ack_s    = ack_sync[1];
  wire rdy_rise = rdy_s & ~rdy_d;
  wire ack_rise = ack_s & ~ack_d;

  assign busy     = (state != S_IDLE);
  assign spi_mosi = tx_sr[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_sync <= '0;
      ack_sync <= '0;
      rdy_d    <= 1'b0;
      ack_d    <= 1'b0;
    end else begin
      rdy_sync <= {rdy_sync[0], hs_rdy};
      ack_sync <= {ack_sync[0], hs_ack};
      rdy_d    <= rdy_s;
      ack_d    <= ack_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rd_data  <= '0;
      div      <= '0;
      bitc     <= '0;
      tmr      <= '0;
      is_rd    <= 1'b0;
      hs_ind   <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
      done     <= 1'b0;
      ack_err  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      done     <= 1'b0;
      ack_err  <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            tx_sr  <= tx_data;
            is_rd  <= 1'b0;
            hs_ind <= 1'b1;
            state  <= S_REQ;
          end else if (rdy_rise) begin
            tx_sr    <= '0;
            is_rd    <= 1'b1;
            spi_cs_n <= 1'b0;
            spi_sclk <= 1'b0;
            div      <= '0;
            bitc     <= '0;
            state    <= S_XFER;
          end
        end
        S_REQ: begin
          if (rdy_s) begin
            hs_ind   <= 1'b0;
            spi_cs_n <= 1'b0;
            spi_sclk <= 1'b0;
            div      <= '0;
            bitc     <= '0;
            state    <= S_XFER;
          end
        end
        S_XFER: begin
          if (div == DW'(HALF - 1)) begin
            div      <= '0;
            spi_sclk <= ~spi_sclk;
            if (!spi_sclk) begin
              rx_sr <= {rx_sr[FRAME_W-2:0], spi_miso};
            end else if (bitc == BW'(FRAME_W - 1)) begin
              spi_cs_n <= 1'b1;
              rd_data  <= rx_sr;
              if (is_rd) begin
                rd_valid <= 1'b1;
                state    <= S_SETL;
              end else begin
                tmr   <= '0;
                state <= S_ACKW;
              end
            end else begin
              tx_sr <= tx_sr << 1;
              bitc  <= bitc + BW'(1);
            end
          end else begin
            div <= div + DW'(1);
          end
        end
        S_ACKW: begin
          if (ack_rise) begin
            done  <= 1'b1;
            state <= S_SETL;
          end else if (tmr == TW'(ACK_TO - 1)) begin
            ack_err <= 1'b1;
            state   <= S_SETL;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        S_SETL: begin
          if (!rdy_s && !ack_s) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module hs_spi_master_chk #(
  parameter int ACK_TO = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic hs_ind,
  input logic done,
  input logic ack_err,
  input logic rd_valid,
  input logic in_req,
  input logic in_wait,
  input logic in_setl,
  input logic rdy_s
);
  localparam int TW = $clog2(ACK_TO + 1);
  logic [TW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (in_wait) wcnt <= wcnt + TW'(1);
    else wcnt <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (spi_cs_n && !spi_sclk && !hs_ind && !done && !ack_err && !rd_valid));
  a_r2_no_clock_while_requesting: assert property (@(posedge clk) disable iff (!rst_n) hs_ind |-> (spi_cs_n && !spi_sclk));
  a_r3_select_after_ready: assert property (@(posedge clk) disable iff (!rst_n) (in_req && rdy_s) |=> (!spi_cs_n && !hs_ind));
  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sclk);
  a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n) (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> $fell(spi_sclk));
  a_r5_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(in_wait));
  a_r6_ack_window: assert property (@(posedge clk) disable iff (!rst_n) in_wait |-> (wcnt < TW'(ACK_TO)));
  a_r7_read_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (spi_cs_n && $past(!spi_cs_n)));
  a_r8_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n) in_setl |-> (spi_cs_n && !hs_ind));
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, ack_err, rd_valid}));
endmodule

bind hs_spi_master hs_spi_master_chk #(.ACK_TO(ACK_TO)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .hs_ind(hs_ind), .done(done), .ack_err(ack_err),
  .rd_valid(rd_valid), .in_req(state == S_REQ), .in_wait(state == S_ACKW),
  .in_setl(state == S_SETL), .rdy_s(rdy_sync[1])
);

// File: tb/tb_hs_spi_master.sv
module tb_hs_spi_master;
  localparam int FW = 8;
  localparam int CD = 4;
  localparam int AT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] tx_data = '0;
  logic busy, done, ack_err, rd_valid, hs_ind, spi_cs_n, spi_sclk, spi_mosi;
  logic [FW-1:0] rd_data;
  logic hs_rdy = 1'b0, hs_ack = 1'b0, spi_miso = 1'b0;

  int checks = 0, errors = 0;
  int n_done = 0, n_err = 0, n_rdv = 0, rises = 0, s_idx = 0;
  logic [FW-1:0] s_word = '0, s_rx = '0;

  always #5 clk = ~clk;

  hs_spi_master #(.FRAME_W(FW), .CLK_DIV(CD), .ACK_TO(AT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .busy(busy),
    .done(done), .ack_err(ack_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .hs_ind(hs_ind), .hs_rdy(hs_rdy), .hs_ack(hs_ack), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always @(negedge spi_cs_n) begin s_idx = 0; spi_miso = s_word[FW-1]; end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    s_idx++;
    if (s_idx < FW) spi_miso = s_word[FW-1-s_idx];
  end
  always @(posedge spi_sclk) begin rises++; s_rx = {s_rx[FW-2:0], spi_mosi}; end
  always @(negedge clk) begin
    if (done) n_done++;
    if (ack_err) n_err++;
    if (rd_valid) n_rdv++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [FW-1:0] d, input logic [FW-1:0] resp, input bit ack_ok);
    int cnt, d0, e0, r0;
    d0 = n_done; e0 = n_err; r0 = n_rdv;
    s_word = resp; s_rx = '0; rises = 0;
    @(negedge clk); start = 1'b1; tx_data = d;
    @(negedge clk); start = 1'b0;
    check(hs_ind && busy, "R2 request raised", int'(hs_ind), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(spi_cs_n && !spi_sclk && hs_ind, "R2 idle bus before ready", int'(spi_cs_n), 1);
    end
    hs_rdy = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (spi_cs_n && cnt < 50);
    check(cnt == 3, "R3 select latency", cnt, 3);
    check(!hs_ind, "R3 request dropped", int'(hs_ind), 0);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!spi_cs_n && cnt < 500);
    check(cnt == FW*CD, "R4 frame length", cnt, FW*CD);
    check(rises == FW, "R4 clock edges", rises, FW);
    check(s_rx == d, "R4 mosi word", int'(s_rx), int'(d));
    check(rd_data == resp, "R4 miso word", int'(rd_data), int'(resp));
    hs_rdy = 1'b0;
    cnt = 0;
    if (ack_ok) begin
      hs_ack = 1'b1;
      do begin @(negedge clk); cnt++; end while (!done && cnt < 100);
      check(cnt == 3, "R5 done latency", cnt, 3);
      @(negedge clk);
      check(!done, "R5 done one cycle", int'(done), 0);
      hs_ack = 1'b0;
    end else begin
      do begin @(negedge clk); cnt++; end while (!ack_err && cnt < 200);
      check(cnt == AT, "R6 timeout latency", cnt, AT);
      hs_ack = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
      hs_ack = 1'b0;
    end
    wait_idle();
    @(negedge clk);
    check(n_done - d0 == (ack_ok ? 1 : 0), "R6 done count", n_done - d0, ack_ok ? 1 : 0);
    check(n_err - e0 == (ack_ok ? 0 : 1), "R6 error count", n_err - e0, ack_ok ? 0 : 1);
    check(n_rdv == r0, "R7 no read strobe on write", n_rdv - r0, 0);
  endtask

  task automatic do_read(input logic [FW-1:0] v);
    int cnt, r0;
    r0 = n_rdv;
    s_word = v; s_rx = '1; rises = 0;
    @(negedge clk); hs_rdy = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; check(!hs_ind, "R7 no request on read", int'(hs_ind), 0); end
      while (spi_cs_n && cnt < 50);
    check(cnt == 3, "R7 read select latency", cnt, 3);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!spi_cs_n && cnt < 500);
    check(cnt == FW*CD, "R4 read frame length", cnt, FW*CD);
    check(rd_valid, "R7 read strobe", int'(rd_valid), 1);
    check(rd_data == v, "R7 read word", int'(rd_data), int'(v));
    check(s_rx == '0, "R7 mosi held low", int'(s_rx), 0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(n_rdv - r0 == 1 && busy, "R8 single read while ready held", n_rdv - r0, 1);
    hs_rdy = 1'b0;
    wait_idle();
    check(!busy, "R8 back to idle", int'(busy), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spi_cs_n && !spi_sclk && !hs_ind && !busy, "R1 in reset", int'(spi_cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n && !spi_sclk && !hs_ind && !busy && !done && !ack_err && !rd_valid,
          "R1 after reset", int'(busy), 0);

    for (int k = 0; k < 16; k++) begin
      logic [FW-1:0] d;
      d = (k == 15) ? '1 : FW'((k * 29 + 3 * k * k) & 8'hFF);
      if (k == 0) d = '0;
      do_write(d, ~d ^ FW'(k), (k % 5) != 4);
    end

    for (int k = 0; k < 16; k++) begin
      logic [FW-1:0] v;
      v = (k == 0) ? '1 : FW'((k * 53 + 7) & 8'hFF);
      if (k == 15) v = '0;
      do_read(v);
    end

    // R8: ack held high after a frame blocks new requests
    begin
      int cnt;
      s_word = 8'h5A;
      @(negedge clk); start = 1'b1; tx_data = 8'hC3;
      @(negedge clk); start = 1'b0;
      @(negedge clk); hs_rdy = 1'b1;
      // R9: start during the frame is ignored
      for (int i = 0; i < 10; i++) @(negedge clk);
      start = 1'b1; tx_data = 8'h11;
      @(negedge clk); start = 1'b0;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!spi_cs_n && cnt < 500);
      hs_rdy = 1'b0; hs_ack = 1'b1;
      do begin @(negedge clk); cnt++; end while (!done && cnt < 600);
      for (int i = 0; i < 4; i++) @(negedge clk);
      start = 1'b1; tx_data = 8'h22;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check(!hs_ind && busy, "R8 start ignored while ack high", int'(hs_ind), 0);
      end
      hs_ack = 1'b0;
      for (int i = 0; i < 4; i++) @(negedge clk);
      check(!busy, "R8 idle after lines low", int'(busy), 0);
      for (int i = 0; i < 4; i++) @(negedge clk);
      check(!hs_ind && spi_cs_n, "R9 busy start had no effect", int'(hs_ind), 0);
      check(n_rdv == 16, "R10 strobe totals", n_rdv, 16);
    end

    do_write(8'hA5, 8'h3C, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule